// File: doc/BRIEF.md
# Alternating Two-Slot Stage Scheduler

This block sequences a job made of n algorithm stages over two reloadable processing slots and two frame memories. The stages run strictly one after another, and each stage consumes what the previous one wrote. Odd-numbered stages run on slot 0 and even-numbered stages on slot 1. While one slot computes stage k, the scheduler asks the idle slot to load the logic for stage k+1. When both the computation and the reload have finished, the roles swap.

The memory steering follows the running slot. Slot 0 reads memory 0 and writes memory 1. Slot 1 reads memory 1 and writes memory 0. The scheduler drives single-cycle run and reconfigure strobes to each slot and collects their completion pulses. It does not touch the data path, the configuration loading protocol or the host side.

A job begins with a start pulse that carries a stage count. Before stage 1, slot 0 is loaded and the scheduler waits for it to report that it is ready. After the last stage, a one-cycle job-done pulse is raised and no further reload is requested.

Top module: `twin_slot_sequencer`

## Requirements
- R1: After reset, busy, job-done, all run strobes and all reconfigure strobes are 0 and the stage index is 0. Whenever busy is 0, no run or reconfigure strobe is high.
- R2: Start sampled high with a count of 1 or more while idle has these effects in the next cycle:
  - a one-cycle reconfigure strobe on slot 0 (cfg_o = 2'b01);
  - busy rises;
  - the stage index becomes 1.
  No run strobe is issued until cfg_done_i[0] has been seen.
- R3: The cycle after cfg_done_i[0] is sampled in the preload phase, run_o pulses 2'b01 for stage 1. In the same cycle, cfg_o pulses 2'b10 if the count is greater than 1, and stays 0 otherwise.
- R4: Stage k runs on slot (k-1) mod 2: run_o[0] pulses only for odd stage indices and run_o[1] only for even ones.
- R5: src_sel_o equals the slot running the current stage and dst_sel_o the other one. Value 0 selects memory 0 and value 1 selects memory 1.
- R6: Stage k+1 begins only when two pulses have been seen, in either order or in the same cycle:
  - run_done_i from the running slot;
  - cfg_done_i from the other slot.
  Its run strobe appears the cycle after the later of the two. Either pulse alone causes no advance.
- R7: For every stage k < n, a reconfigure strobe to the slot not running stage k is issued in the same cycle as the run strobe of stage k. For stage n, no reconfigure strobe is issued.
- R8: The cycle after run_done_i of stage n is sampled:
  - job_done_o is high for exactly one cycle;
  - busy is 0;
  - no strobe is issued.
- R9: Start with a count of 0 gives a job-done pulse in the next cycle, with no strobes and busy staying 0.
- R10: Start is ignored while busy: the running job keeps its count and stage, and no new reconfigure strobe appears.
- R11: run_done_i from the slot that is not running, and cfg_done_i from the slot that is running, are ignored.
- R12: Each of run_o and cfg_o has at most one bit high. Neither targets the same slot in the same cycle. Both are single-cycle pulses per decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a job (accepted when idle) |
| stage_count_i | input | CNT_W | Number of stages in the job |
| run_o | output | 2 | Per-slot run strobe |
| run_done_i | input | 2 | Per-slot stage-complete pulse |
| cfg_o | output | 2 | Per-slot reconfigure strobe |
| cfg_done_i | input | 2 | Per-slot reconfigured pulse |
| src_sel_o | output | 1 | Memory read by the running slot |
| dst_sel_o | output | 1 | Memory written by the running slot |
| stage_idx_o | output | CNT_W | Current stage number (1-based) |
| busy_o | output | 1 | Job in progress |
| job_done_o | output | 1 | One-cycle end-of-job pulse |

## Verification
A corrupted active-slot register shows up in the first strobe issued after the fault:
- the run strobe lands on a slot whose parity disagrees with the stage index;
- the memory selects point the wrong way.

A sticky completion flag that is set wrongly, or never cleared, makes the stage index advance one cycle after only one of the two required pulses. Directed sequences that deliver those pulses apart catch this at once. A bad stage-count latch is visible at the end of the job: job-done arrives a stage early or late, or a reconfigure strobe appears on the last stage.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int NSLOT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } tsq_state_e;
endpackage

// File: rtl/tsq_stage_track.sv
module tsq_stage_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o,
  output logic             next_last_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] idx_inc;
  logic             upd_en;

  assign idx_inc = idx_q + ONE;
  assign upd_en  = load_i | adv_i;

  always_comb begin
    total_d = total_q;
    idx_d   = idx_q;
    if (load_i) begin
      total_d = count_i;
      idx_d   = ONE;
    end else if (adv_i) begin
      idx_d   = idx_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      idx_q   <= '0;
    end else if (upd_en) begin
      total_q <= total_d;
      idx_q   <= idx_d;
    end
  end

  assign idx_o       = idx_q;
  assign last_o      = (idx_q == total_q);
  assign next_last_o = (idx_inc == total_q);
endmodule

// File: rtl/tsq_join.sv
module tsq_join (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  input  logic need_cfg_i,
  input  logic run_done_i,
  input  logic cfg_done_i,
  output logic ready_o
);
  logic run_seen_q, run_seen_d;
  logic cfg_seen_q, cfg_seen_d;
  logic flag_en;

  assign flag_en = clr_i | en_i;

  always_comb begin
    run_seen_d = run_seen_q;
    cfg_seen_d = cfg_seen_q;
    if (clr_i) begin
      run_seen_d = 1'b0;
      cfg_seen_d = 1'b0;
    end else if (en_i) begin
      if (run_done_i) run_seen_d = 1'b1;
      if (cfg_done_i) cfg_seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_seen_q <= 1'b0;
      cfg_seen_q <= 1'b0;
    end else if (flag_en) begin
      run_seen_q <= run_seen_d;
      cfg_seen_q <= cfg_seen_d;
    end
  end

  assign ready_o = en_i & (run_seen_q | run_done_i) &
                   (~need_cfg_i | cfg_seen_q | cfg_done_i);
endmodule

// File: rtl/tsq_steer.sv
module tsq_steer
  import tsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             home_i,
  input  logic             flip_i,
  input  logic             run_fire_i,
  input  logic             run_slot_i,
  input  logic             cfg_fire_i,
  input  logic             cfg_slot_i,
  output logic             active_o,
  output logic             src_sel_o,
  output logic             dst_sel_o,
  output logic [NSLOT-1:0] run_o,
  output logic [NSLOT-1:0] cfg_o
);
  logic             act_q, act_d;
  logic             act_en;
  logic [NSLOT-1:0] run_d, cfg_d;
  logic [NSLOT-1:0] run_q, cfg_q;

  assign act_en = home_i | flip_i;

  always_comb begin
    act_d = act_q;
    if (home_i)      act_d = 1'b0;
    else if (flip_i) act_d = ~act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (act_en) act_q <= act_d;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign run_d[g] = run_fire_i & (run_slot_i == g[0]);
    assign cfg_d[g] = cfg_fire_i & (cfg_slot_i == g[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[g] <= 1'b0;
        cfg_q[g] <= 1'b0;
      end else begin
        run_q[g] <= run_d[g];
        cfg_q[g] <= cfg_d[g];
      end
    end
  end

  assign active_o  = act_q;
  assign src_sel_o = act_q;
  assign dst_sel_o = ~act_q;
  assign run_o     = run_q;
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/twin_slot_sequencer.sv
module twin_slot_sequencer
  import tsq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] stage_count_i,
  output logic [1:0]       run_o,
  input  logic [1:0]       run_done_i,
  output logic [1:0]       cfg_o,
  input  logic [1:0]       cfg_done_i,
  output logic             src_sel_o,
  output logic             dst_sel_o,
  output logic [CNT_W-1:0] stage_idx_o,
  output logic             busy_o,
  output logic             job_done_o
);
  tsq_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       load, adv, home, flip;
  logic       run_fire, run_slot, cfg_fire, cfg_slot;
  logic       join_en, join_clr, ready;
  logic       last, next_last, active;
  logic       cnt_zero;

  assign cnt_zero = (stage_count_i == '0);

  tsq_stage_track #(.CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .count_i     (stage_count_i),
    .adv_i       (adv),
    .idx_o       (stage_idx_o),
    .last_o      (last),
    .next_last_o (next_last)
  );

  tsq_join u_join (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (join_en),
    .clr_i      (join_clr),
    .need_cfg_i (~last),
    .run_done_i (run_done_i[active]),
    .cfg_done_i (cfg_done_i[~active]),
    .ready_o    (ready)
  );

  tsq_steer u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .home_i     (home),
    .flip_i     (flip),
    .run_fire_i (run_fire),
    .run_slot_i (run_slot),
    .cfg_fire_i (cfg_fire),
    .cfg_slot_i (cfg_slot),
    .active_o   (active),
    .src_sel_o  (src_sel_o),
    .dst_sel_o  (dst_sel_o),
    .run_o      (run_o),
    .cfg_o      (cfg_o)
  );

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    load     = 1'b0;
    adv      = 1'b0;
    home     = 1'b0;
    flip     = 1'b0;
    run_fire = 1'b0;
    run_slot = 1'b0;
    cfg_fire = 1'b0;
    cfg_slot = 1'b0;
    join_en  = 1'b0;
    join_clr = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (cnt_zero) begin
            done_d = 1'b1;
          end else begin
            load     = 1'b1;
            home     = 1'b1;
            cfg_fire = 1'b1;
            cfg_slot = 1'b0;
            join_clr = 1'b1;
            state_d  = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        if (cfg_done_i[0]) begin
          run_fire = 1'b1;
          run_slot = 1'b0;
          cfg_fire = ~last;
          cfg_slot = 1'b1;
          state_d  = ST_RUN;
        end
      end
      ST_RUN: begin
        join_en = 1'b1;
        if (ready) begin
          join_clr = 1'b1;
          if (last) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            adv      = 1'b1;
            flip     = 1'b1;
            run_fire = 1'b1;
            run_slot = ~active;
            cfg_fire = ~next_last;
            cfg_slot = active;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign job_done_o = done_q;
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       run_o,
  input logic [1:0]       cfg_o,
  input logic             src_sel_o,
  input logic             dst_sel_o,
  input logic [CNT_W-1:0] stage_idx_o,
  input logic             busy_o,
  input logic             job_done_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (run_o == 2'b00 && cfg_o == 2'b00));

  assert_start_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (cfg_o == 2'b01 && run_o == 2'b00 && stage_idx_o == 1));

  assert_odd_slot0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_o[0] |-> stage_idx_o[0]);

  assert_even_slot1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_o[1] |-> !stage_idx_o[0]);

  assert_steer_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_o[0] |-> (src_sel_o == 1'b0 && dst_sel_o == 1'b1));

  assert_steer_slot1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_o[1] |-> (src_sel_o == 1'b1 && dst_sel_o == 1'b0));

  assert_other_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o & cfg_o) == 2'b00);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    job_done_o |=> !job_done_o);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    job_done_o |-> (!busy_o && run_o == 2'b00 && cfg_o == 2'b00));

  assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_o) && $onehot0(cfg_o));
endmodule

bind twin_slot_sequencer tsq_checker #(.CNT_W(CNT_W)) u_tsq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_o       (run_o),
  .cfg_o       (cfg_o),
  .src_sel_o   (src_sel_o),
  .dst_sel_o   (dst_sel_o),
  .stage_idx_o (stage_idx_o),
  .busy_o      (busy_o),
  .job_done_o  (job_done_o)
);

// File: tb/test_twin_slot_sequencer.sv
`timescale 1ns/1ps
module test_twin_slot_sequencer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [CW-1:0] count;
  logic [1:0]    run_o, run_done, cfg_o, cfg_done;
  logic          src_sel, dst_sel, busy, job_done;
  logic [CW-1:0] stage_idx;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  twin_slot_sequencer #(.CNT_W(CW)) i_twin_slot_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stage_count_i(count),
    .run_o(run_o), .run_done_i(run_done), .cfg_o(cfg_o), .cfg_done_i(cfg_done),
    .src_sel_o(src_sel), .dst_sel_o(dst_sel), .stage_idx_o(stage_idx),
    .busy_o(busy), .job_done_o(job_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start(input int n);
    start = 1'b1;
    count = CW'(n);
    tick();
    start = 1'b0;
    count = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; count = '0; run_done = '0; cfg_done = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset job_done", job_done, 0);
    chk("R1 reset strobes", {run_o, cfg_o}, 0);
    chk("R1 reset stage", stage_idx, 0);
  endtask

  task automatic t_zero_count();
    do_start(0);
    chk("R9 zero count done pulse", job_done, 1);
    chk("R9 zero count busy", busy, 0);
    chk("R9 zero count strobes", {run_o, cfg_o}, 0);
    tick();
    chk("R9 done one cycle", job_done, 0);
    chk("R9 stays idle", busy, 0);
  endtask

  task automatic run_job(input int n, input int mode, input bit wrong, input bit restart);
    do_start(n);
    chk("R2 cfg strobe slot0", cfg_o, 1);
    chk("R2 busy rises", busy, 1);
    chk("R2 stage one", stage_idx, 1);
    chk("R2 no run yet", run_o, 0);
    repeat (2) tick();
    chk("R2 waits for reconfigured", run_o, 0);
    chk("R12 cfg is a pulse", cfg_o, 0);
    cfg_done = 2'b01; tick(); cfg_done = 2'b00;
    chk("R3 run slot0", run_o, 1);
    chk("R3 preload slot1", cfg_o, (n > 1) ? 2 : 0);
    chk("R5 src stage1", src_sel, 0);
    chk("R5 dst stage1", dst_sel, 1);
    for (int k = 1; k <= n; k++) begin
      int act;
      int oth;
      act = (k - 1) % 2;
      oth = 1 - act;
      repeat (2) tick();
      chk("R12 strobes are pulses", {run_o, cfg_o}, 0);
      if (k == 1 && wrong) begin
        run_done = 2'(1 << oth); cfg_done = 2'(1 << act); tick();
        run_done = '0; cfg_done = '0;
        chk("R11 wrong slot ignored stage", stage_idx, 1);
        chk("R11 wrong slot no run", run_o, 0);
      end
      if (k == 1 && restart) begin
        start = 1'b1; count = 8'd7; tick(); start = 1'b0; count = '0;
        chk("R10 start ignored cfg", cfg_o, 0);
        chk("R10 start ignored stage", stage_idx, 1);
        chk("R10 still busy", busy, 1);
      end
      if (k == n) begin
        run_done = 2'(1 << act); tick(); run_done = '0;
        chk("R8 job done pulse", job_done, 1);
        chk("R8 busy falls", busy, 0);
        chk("R8 no strobes", {run_o, cfg_o}, 0);
        tick();
        chk("R8 done one cycle", job_done, 0);
        chk("R8 quiet after", {run_o, cfg_o}, 0);
      end else begin
        if (mode == 0) begin
          run_done = 2'(1 << act); tick(); run_done = '0;
          chk("R6 done alone no advance", stage_idx, k);
          chk("R6 done alone no run", run_o, 0);
          cfg_done = 2'(1 << oth); tick(); cfg_done = '0;
        end else if (mode == 1) begin
          cfg_done = 2'(1 << oth); tick(); cfg_done = '0;
          chk("R6 cfg alone no advance", stage_idx, k);
          chk("R6 cfg alone no run", run_o, 0);
          run_done = 2'(1 << act); tick(); run_done = '0;
        end else begin
          run_done = 2'(1 << act); cfg_done = 2'(1 << oth); tick();
          run_done = '0; cfg_done = '0;
        end
        chk("R6 advance", stage_idx, k + 1);
        chk("R4 run on slot", run_o, 1 << oth);
        chk("R7 cfg other slot", cfg_o, (k + 1 < n) ? (1 << act) : 0);
        chk("R5 src follows slot", src_sel, oth);
        chk("R5 dst opposite", dst_sel, act);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero_count();
    run_job(1, 0, 1'b0, 1'b0);
    run_job(4, 0, 1'b0, 1'b0);
    run_job(5, 1, 1'b1, 1'b0);
    run_job(3, 2, 1'b0, 1'b1);
    run_job(2, 1, 1'b1, 1'b1);
    run_job(6, 2, 1'b1, 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule